// File: doc/BRIEF.md
# Packed-Slot Zero-Stack Processor Core

A compact 16-bit processor that executes code held as packets. Each 16-bit packet word carries five 3-bit opcodes. The core has a three-cell evaluation stack and no return stack. It has no call or return instruction. Constants come from inline words that follow the packet. Control flow has one form: a jump that is taken when a flag is zero. The core drives a word-addressed memory bus with one access per cycle. Read data is expected back from memory in the same cycle.

The core runs as a two-state machine. In the state `S_FETCH` it reads the packet at the program counter. In the state `S_EXEC` it executes one slot per cycle. The transitions are:

- **FETCH→EXEC**: the fetched packet holds at least one non-NOP slot.
- **FETCH→FETCH**: the fetched packet is all NOP.
- **EXEC→EXEC**: more live slots remain in the packet.
- **EXEC→FETCH on jump**: a ZGO is taken.
- **EXEC→FETCH on tail**: the current slot is slot 4, or every later slot is NOP.

A taken jump drops the rest of the packet, together with any inline words that those dropped slots would have consumed.

Top module: `pkt_stack_cpu`

## Requirements
- R1: Synchronous reset, active high, clears the program counter and the stack and enters `S_FETCH`. In the first cycle after reset the core shows `mem_addr`=0, `mem_rd`=1 and `mem_wr`=0.
- R2: The five slots of a packet are packed from the MSB. Slot 0 is bits 15:13 and slot 4 is bits 3:1; bit 0 is ignored. Slots run in order from 0 to 4. The opcodes are: 0 NOP, 1 LIT, 2 FETCH, 3 STORE, 4 ADD, 5 AND, 6 XOR, 7 ZGO.
- R3: LIT reads the word at the program counter, pushes it, and advances the program counter. Literals are therefore taken in slot order from the words that follow the packet.
- R4: FETCH replaces the top cell T with the memory word at address T. STORE writes the second cell N to address T and pops two cells.
- R5: ADD, AND and XOR replace N and T with N op T and pop one cell. ADD wraps modulo 2^16.
- R6: The stack holds exactly three cells. A push onto the stack discards the bottom cell. A pop copies the bottom cell upward.
- R7: ZGO pops the target T and then the flag N. When the flag is zero, the next cycle fetches the packet at the target. The later slots and their inline words are never executed, whichever slot held the ZGO.
- R8: When the ZGO flag is non-zero, both cells are popped and execution continues with the next slot.
- R9: When every slot after the current one is NOP, the next cycle is a packet fetch. A packet that is all NOP costs only its fetch cycle.
- R10: `mem_rd` and `mem_wr` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock; everything updates on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | 16 | Word address of the current access |
| mem_rdata | input | 16 | Read data, valid in the same cycle as the address |
| mem_wdata | output | 16 | Write data for a STORE |
| mem_rd | output | 1 | Read request for a packet, literal or FETCH |
| mem_wr | output | 1 | Write request; memory captures on the rising edge |

## Verification
A packet fetch takes one cycle and each executed slot takes one cycle. A store therefore appears on the bus in a cycle that can be counted exactly from reset: cycle 0 is the first packet fetch, and each earlier live slot adds one cycle. The bench counts clock edges from the release of reset. It predicts each store's cycle, address and data from the program, and compares all three at the falling edge of that cycle. Any skipped NOP cycle, executed dropped literal or missed jump therefore shows up as a mismatch in timing or data.

// File: rtl/pkt_cpu_pkg.sv
package pkt_cpu_pkg;
    typedef enum logic [2:0] {
        OP_NOP   = 3'd0,
        OP_LIT   = 3'd1,
        OP_FETCH = 3'd2,
        OP_STORE = 3'd3,
        OP_ADD   = 3'd4,
        OP_AND   = 3'd5,
        OP_XOR   = 3'd6,
        OP_ZGO   = 3'd7
    } op_e;

    typedef enum logic {
        S_FETCH = 1'b0,
        S_EXEC  = 1'b1
    } fsm_e;

    typedef enum logic [2:0] {
        STK_HOLD,
        STK_PUSH,
        STK_REPL,
        STK_POP1,
        STK_POP2
    } stk_e;
endpackage

// File: rtl/pkt_slot_dec.sv
module pkt_slot_dec
    import pkt_cpu_pkg::*;
#(
    parameter int W     = 16,
    parameter int SLOTS = 5,
    parameter int OPW   = 3,
    parameter int SW    = 3
) (
    input  logic [W-1:0]  ir,
    input  logic [SW-1:0] slot,
    output op_e           op,
    output logic          last
);
    localparam int PKW = SLOTS * OPW;

    logic [PKW-1:0] body;
    logic [PKW-1:0] rest;

    always_comb begin
        body = ir[W-1 -: PKW];
        op   = op_e'(body[PKW-1 - OPW*int'(slot) -: OPW]);
        rest = body << (OPW * (int'(slot) + 1));
        last = (rest == '0);
    end
endmodule

// File: rtl/pkt_alu.sv
module pkt_alu
    import pkt_cpu_pkg::*;
#(
    parameter int W = 16
) (
    input  op_e          op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y
);
    always_comb begin
        case (op)
            OP_ADD:  y = a + b;
            OP_AND:  y = a & b;
            OP_XOR:  y = a ^ b;
            default: y = b;
        endcase
    end
endmodule

// File: rtl/pkt_stack3.sv
module pkt_stack3
    import pkt_cpu_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  stk_e         ctl,
    input  logic [W-1:0] din,
    output logic [W-1:0] tos,
    output logic [W-1:0] nos
);
    logic [W-1:0] bos;

    always_ff @(posedge clk) begin
        if (rst) begin
            tos <= '0;
            nos <= '0;
            bos <= '0;
        end else begin
            unique case (ctl)
                STK_HOLD: ;
                STK_PUSH: begin
                    tos <= din;
                    nos <= tos;
                    bos <= nos;
                end
                STK_REPL: tos <= din;
                STK_POP1: begin
                    tos <= din;
                    nos <= bos;
                end
                STK_POP2: begin
                    tos <= bos;
                    nos <= bos;
                end
                default: ;
            endcase
        end
    end

    // R6: a push shifts the old top and second cell down one place
    a_r6_push_shift: assert property (@(posedge clk) disable iff (rst)
        (ctl == STK_PUSH) |=> (nos == $past(tos)) && (bos == $past(nos)));

    // R6: a double pop leaves the old bottom cell in all three places
    a_r6_pop_dup: assert property (@(posedge clk) disable iff (rst)
        (ctl == STK_POP2) |=> (tos == $past(bos)) && (nos == $past(bos)));
endmodule

// File: rtl/pkt_stack_cpu.sv
module pkt_stack_cpu
    import pkt_cpu_pkg::*;
#(
    parameter int W     = 16,
    parameter int SLOTS = 5,
    parameter int OPW   = 3
) (
    input  logic         clk,
    input  logic         rst,
    output logic [W-1:0] mem_addr,
    input  logic [W-1:0] mem_rdata,
    output logic [W-1:0] mem_wdata,
    output logic         mem_rd,
    output logic         mem_wr
);
    localparam int PKW = SLOTS * OPW;
    localparam int SW  = $clog2(SLOTS + 1);

    fsm_e          state, nstate;
    logic [W-1:0]  pc;
    logic [W-1:0]  ir;
    logic [SW-1:0] slot;
    op_e           op;
    logic          last;
    logic [W-1:0]  tos, nos, alu_y, stk_din;
    stk_e          stk_ctl;
    logic          zgo_take;

    pkt_slot_dec #(.W(W), .SLOTS(SLOTS), .OPW(OPW), .SW(SW)) u_dec (
        .ir(ir), .slot(slot), .op(op), .last(last)
    );

    pkt_alu #(.W(W)) u_alu (
        .op(op), .a(nos), .b(tos), .y(alu_y)
    );

    pkt_stack3 #(.W(W)) u_stk (
        .clk(clk), .rst(rst), .ctl(stk_ctl), .din(stk_din),
        .tos(tos), .nos(nos)
    );

    assign zgo_take = (state == S_EXEC) && (op == OP_ZGO) && (nos == '0);

    // next-state logic
    always_comb begin
        nstate = state;
        unique case (state)
            S_FETCH: if (mem_rdata[W-1 -: PKW] != '0) nstate = S_EXEC;
            S_EXEC:  if (zgo_take || last) nstate = S_FETCH;
            default: nstate = S_FETCH;
        endcase
    end

    // state and sequencing registers
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= S_FETCH;
            pc    <= '0;
            ir    <= '0;
            slot  <= '0;
        end else begin
            state <= nstate;
            unique case (state)
                S_FETCH: begin
                    ir   <= mem_rdata;
                    pc   <= pc + 1'b1;
                    slot <= '0;
                end
                S_EXEC: begin
                    slot <= slot + 1'b1;
                    if (op == OP_LIT) pc <= pc + 1'b1;
                    else if (zgo_take) pc <= tos;
                end
                default: ;
            endcase
        end
    end

    // outputs: bus and stack control
    always_comb begin
        mem_addr  = pc;
        mem_wdata = nos;
        mem_rd    = 1'b0;
        mem_wr    = 1'b0;
        stk_ctl   = STK_HOLD;
        stk_din   = mem_rdata;
        unique case (state)
            S_FETCH: mem_rd = 1'b1;
            S_EXEC: begin
                unique case (op)
                    OP_NOP: ;
                    OP_LIT: begin
                        mem_rd  = 1'b1;
                        stk_ctl = STK_PUSH;
                    end
                    OP_FETCH: begin
                        mem_addr = tos;
                        mem_rd   = 1'b1;
                        stk_ctl  = STK_REPL;
                    end
                    OP_STORE: begin
                        mem_addr = tos;
                        mem_wr   = 1'b1;
                        stk_ctl  = STK_POP2;
                    end
                    OP_ADD, OP_AND, OP_XOR: begin
                        stk_ctl = STK_POP1;
                        stk_din = alu_y;
                    end
                    OP_ZGO: stk_ctl = STK_POP2;
                    default: ;
                endcase
            end
            default: ;
        endcase
    end

    // R1: reset returns the core to packet fetch at address zero
    a_r1_reset_home: assert property (@(posedge clk)
        rst |=> (state == S_FETCH) && (pc == '0));

    // R10: a single access per cycle
    a_r10_one_access: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr));

    // R7: a taken jump fetches the target packet next
    a_r7_jump_fetch: assert property (@(posedge clk) disable iff (rst)
        zgo_take |=> (state == S_FETCH) && (mem_addr == $past(tos)) && mem_rd);

    // R9: nothing but NOP left means fetch the next packet
    a_r9_tail_fetch: assert property (@(posedge clk) disable iff (rst)
        (state == S_EXEC && last) |=> (state == S_FETCH));

    // R3: each literal consumes one inline word
    a_r3_lit_step: assert property (@(posedge clk) disable iff (rst)
        (state == S_EXEC && op == OP_LIT) |=> (pc == $past(pc) + 1'b1));

    // R8: an untaken jump moves on in the same packet unless it was the tail
    a_r8_fall_through: assert property (@(posedge clk) disable iff (rst)
        (state == S_EXEC && op == OP_ZGO && nos != '0 && !last)
        |=> (state == S_EXEC) && (pc == $past(pc)));
endmodule

// File: tb/sim_pkt_stack_cpu.sv
module sim_pkt_stack_cpu;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] mem_addr, mem_rdata, mem_wdata;
    logic        mem_rd, mem_wr;
    logic [15:0] mem [0:511];
    int          cyc = 0;
    int          n_run = 0;
    int          n_fail = 0;

    typedef struct {
        int          cyc;
        logic [15:0] addr;
        logic [15:0] data;
    } store_t;
    store_t sb[$];

    always #2 clk = ~clk;

    pkt_stack_cpu u0 (
        .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .mem_wdata(mem_wdata), .mem_rd(mem_rd), .mem_wr(mem_wr)
    );

    assign mem_rdata = mem[mem_addr[8:0]];

    always @(posedge clk) begin
        if (mem_wr) mem[mem_addr[8:0]] <= mem_wdata;
        if (rst) cyc <= 0;
        else     cyc <= cyc + 1;
    end

    function automatic logic [15:0] pk(input int a, input int b, input int c,
                                       input int d, input int e);
        return {a[2:0], b[2:0], c[2:0], d[2:0], e[2:0], 1'b0};
    endfunction

    task automatic check(input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic expect_store(input int c, input logic [15:0] a,
                                input logic [15:0] d);
        store_t s;
        s.cyc = c; s.addr = a; s.data = d;
        sb.push_back(s);
    endtask

    // monitor: compare each write against the scoreboard head
    always @(negedge clk) begin
        if (!rst && mem_wr) begin
            if (sb.size() == 0) begin
                check("R7 unexpected store", {mem_addr, mem_wdata}, 32'h0);
            end else begin
                store_t s;
                s = sb.pop_front();
                check("R2-store cycle", cyc, s.cyc);
                check("R4 store addr/data", {mem_addr, mem_wdata}, {s.addr, s.data});
            end
        end
    end

    initial begin
        #400000;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 512; i++) mem[i] = 16'h0;
        // R5 add, R3 literal order
        mem[0]  = pk(1,1,4,1,3); mem[1] = 16'd5; mem[2] = 16'd7; mem[3] = 16'h100;
        // R5 xor
        mem[4]  = pk(1,1,6,1,3); mem[5] = 16'h00F0; mem[6] = 16'h0FF0; mem[7] = 16'h101;
        // R5 and
        mem[8]  = pk(1,1,5,1,3); mem[9] = 16'hFF0F; mem[10] = 16'h0F0F; mem[11] = 16'h102;
        // R4 fetch, R9 trailing NOP
        mem[12] = pk(1,2,1,3,0); mem[13] = 16'h100; mem[14] = 16'h103;
        // R7 taken in slot 2; words 18,19 must never run
        mem[15] = pk(1,1,7,1,3); mem[16] = 16'h0; mem[17] = 16'd20;
        mem[18] = 16'hDEAD; mem[19] = 16'h104;
        // R8 untaken
        mem[20] = pk(1,1,7,1,1); mem[21] = 16'd5; mem[22] = 16'd31;
        mem[23] = 16'hBEEF; mem[24] = 16'h105;
        mem[25] = pk(3,0,0,0,0);
        mem[26] = pk(0,0,0,0,0);                       // R9 all-NOP packet
        // R6 overflow discards bottom
        mem[27] = pk(1,1,1,1,3); mem[28] = 16'd1; mem[29] = 16'd2;
        mem[30] = 16'h55; mem[31] = 16'h106;
        // R6 pops duplicate bottom
        mem[32] = pk(1,3,1,3,0); mem[33] = 16'h107; mem[34] = 16'h108;
        // R7 taken in slot 3, slot 4 literal dropped
        mem[35] = pk(1,1,1,7,1); mem[36] = 16'h77; mem[37] = 16'h0;
        mem[38] = 16'd40; mem[39] = 16'h1234;
        mem[40] = pk(1,3,0,0,0); mem[41] = 16'h109;
        // R7 taken in slot 4
        mem[42] = pk(1,1,1,1,7); mem[43] = 16'hAA; mem[44] = 16'hBB;
        mem[45] = 16'h0; mem[46] = 16'd48; mem[47] = 16'hFFFF;
        mem[48] = pk(1,3,0,0,0); mem[49] = 16'h10A;
        // halt loop
        mem[50] = pk(1,1,7,0,0); mem[51] = 16'h0; mem[52] = 16'd50;

        expect_store(5,  16'h100, 16'd12);
        expect_store(11, 16'h101, 16'h0F00);
        expect_store(17, 16'h102, 16'h0F0F);
        expect_store(22, 16'h103, 16'd12);
        expect_store(34, 16'h105, 16'hBEEF);
        expect_store(41, 16'h106, 16'h55);
        expect_store(44, 16'h107, 16'd2);
        expect_store(46, 16'h108, 16'd2);
        expect_store(54, 16'h109, 16'h77);
        expect_store(63, 16'h10A, 16'hBB);

        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: first cycle after reset
        check("R1 addr", mem_addr, 16'h0);
        check("R1 rd", mem_rd, 1'b1);
        check("R1 wr", mem_wr, 1'b0);

        repeat (120) @(negedge clk);
        check("R7 all stores seen", sb.size(), 0);
        check("R7 dropped literal store", mem[16'h104], 16'h0);
        check("R10 no stray write", mem[16'h1FF], 16'h0);

        // R1: reset in the middle of a run
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1 rerun addr", mem_addr, 16'h0);
        check("R1 rerun rd", mem_rd, 1'b1);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule